// File: doc/BRIEF.md
# Saturating Halfword-Pair Sum Unit

This unit works on two 128-bit operand vectors, A and B. Each vector is split into four independent 32-bit word lanes. In every lane the two signed 16-bit halves of A's word are sign-extended and added to B's word, which is also sign-extended and acts as the running accumulator. The three-term sum is computed wide enough that it can never wrap. It is then clamped into the signed 32-bit range and written to the matching lane of a 128-bit result.

A flag travels with each result and tells whether any lane of that operation was clamped. A separate status bit stays set once any accepted operation has clamped, and only an explicit clear input drops it.

Operands enter through a valid/ready handshake and results leave through one. There is one register stage between them:
- A result appears one cycle after its operands are accepted.
- Input ready is high whenever the output register is empty or is being drained in the same cycle.
- While the output is valid and the consumer holds ready low, the result is held unchanged and no new operands are taken.

Top module: `hpsum_unit`

## Requirements
- R1: For lane k (k = 0..3), bits [127-32k -: 32] of out_sum equal the sign-extended sum of B's word in that lane plus A's upper halfword (bits [127-32k -: 16]) plus A's lower halfword (bits [111-32k -: 16]), whenever that sum lies within the signed 32-bit range.
- R2: A lane whose sum is greater than 2^31-1 yields 32'h7FFF_FFFF in that lane.
- R3: A lane whose sum is less than -2^31 yields 32'h8000_0000 in that lane.
- R4: A lane whose sum equals exactly 2^31-1 or exactly -2^31 passes the sum through unchanged and does not count as saturated.
- R5: Lanes are independent: clamping in one lane leaves the other lanes' results unchanged.
- R6: out_sat, which travels with each result, is 1 exactly when at least one lane of that operation was clamped.
- R7: sat_sticky becomes 1 in the cycle where a clamped result appears, and it holds until sat_clear is sampled high. If a clear and a clamping accept occur in the same cycle, the bit still ends up set.
- R8: An operation accepted on a clock edge (in_valid and in_ready both high) presents out_valid=1 with its result after that edge. in_ready equals (!out_valid || out_ready).
- R9: While out_valid=1 and out_ready=0, out_valid, out_sum and out_sat stay unchanged and in_ready is 0.
- R10: While rst_n is low, out_valid and sat_sticky are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Unit can take an operand pair |
| in_a | input | 128 | Halfword-pair operand, lane 0 in the top 32 bits |
| in_b | input | 128 | Accumulator words, lane 0 in the top 32 bits |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | 128 | Clamped lane sums |
| out_sat | output | 1 | This result had at least one clamped lane |
| sat_clear | input | 1 | Clears the sticky saturation bit |
| sat_sticky | output | 1 | Sticky saturation status |

## Verification
The bench drives every lane to exactly 2^31-1 and exactly -2^31, and also one step past each limit. A clamp test using the wrong comparison would flag or clamp the exact limits, or would let the out-of-range sums wrap to the opposite sign. It mixes one clamped lane with ordinary lanes, so that a shared clamp or a wrong lane slice would corrupt the neighbouring lanes. It also exercises an output stall and the clear-versus-set collision on the sticky bit: a wrong ready equation would drop or overwrite the held result, and a wrong priority would lose a fresh saturation.

// File: rtl/hpsum_pkg.sv
package hpsum_pkg;
  localparam int unsigned HP_LANES  = 4;
  localparam int unsigned HP_WORD_W = 32;
  localparam int unsigned HP_HALF_W = HP_WORD_W / 2;
  localparam int unsigned HP_SUM_W  = HP_WORD_W + 2;
endpackage

// File: rtl/hpsum_lane.sv
module hpsum_lane #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SUM_W  = 34
) (
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic [WORD_W-1:0] res,
  output logic              sat
);
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned TOP_W  = SUM_W - WORD_W + 1;

  logic [HALF_W-1:0] half_hi, half_lo;
  logic [SUM_W-1:0]  ext_hi, ext_lo, ext_b, sum;
  logic [TOP_W-1:0]  top;
  logic              pos_ovf, neg_ovf;

  always_comb begin
    half_hi = word_a[WORD_W-1 -: HALF_W];
    half_lo = word_a[HALF_W-1:0];
    ext_hi  = {{(SUM_W-HALF_W){half_hi[HALF_W-1]}}, half_hi};
    ext_lo  = {{(SUM_W-HALF_W){half_lo[HALF_W-1]}}, half_lo};
    ext_b   = {{(SUM_W-WORD_W){word_b[WORD_W-1]}}, word_b};
    sum     = ext_b + ext_hi + ext_lo;
    top     = sum[SUM_W-1:WORD_W-1];
    pos_ovf = !sum[SUM_W-1] && (|top);
    neg_ovf = sum[SUM_W-1] && !(&top);
    sat     = pos_ovf || neg_ovf;
    if (pos_ovf)      res = {1'b0, {(WORD_W-1){1'b1}}};
    else if (neg_ovf) res = {1'b1, {(WORD_W-1){1'b0}}};
    else              res = sum[WORD_W-1:0];
  end
endmodule

// File: rtl/hpsum_stage.sv
module hpsum_stage #(
  parameter int unsigned W = 129
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_data <= in_data;
    end
  end
endmodule

// File: rtl/hpsum_sticky.sv
module hpsum_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set || (flag && !clear);
  end
endmodule

// File: rtl/hpsum_unit.sv
module hpsum_unit
  import hpsum_pkg::*;
#(
  parameter int unsigned LANES  = HP_LANES,
  parameter int unsigned WORD_W = HP_WORD_W,
  parameter int unsigned SUM_W  = HP_SUM_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*WORD_W-1:0] in_a,
  input  logic [LANES*WORD_W-1:0] in_b,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*WORD_W-1:0] out_sum,
  output logic                    out_sat,
  input  logic                    sat_clear,
  output logic                    sat_sticky
);
  localparam int unsigned VEC_W = LANES * WORD_W;

  logic [VEC_W-1:0] sum_vec;
  logic [LANES-1:0] lane_sat;
  logic             any_sat;
  logic             accept;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hpsum_lane #(.WORD_W(WORD_W), .SUM_W(SUM_W)) i_lane (
      .word_a (in_a[VEC_W-1-g*WORD_W -: WORD_W]),
      .word_b (in_b[VEC_W-1-g*WORD_W -: WORD_W]),
      .res    (sum_vec[VEC_W-1-g*WORD_W -: WORD_W]),
      .sat    (lane_sat[g])
    );
  end

  assign any_sat = |lane_sat;
  assign accept  = in_valid && in_ready;

  hpsum_stage #(.W(VEC_W+1)) i_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({sum_vec, any_sat}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  ({out_sum, out_sat})
  );

  hpsum_sticky i_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (sat_clear),
    .set   (accept && any_sat),
    .flag  (sat_sticky)
  );
endmodule

// File: rtl/hpsum_unit_chk.sv
module hpsum_unit_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_sum,
  input logic             out_sat,
  input logic             sat_clear,
  input logic             sat_sticky
);
  // R10
  rst_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !sat_sticky));

  // R8
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_sat)));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !sat_clear) |=> sat_sticky);

  // R7
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clear && !(in_valid && in_ready)) |=> !sat_sticky);

  // R6
  sat_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!out_sat || sat_sticky));
endmodule

bind hpsum_unit hpsum_unit_chk #(.VEC_W(LANES*WORD_W)) i_hpsum_unit_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sum    (out_sum),
  .out_sat    (out_sat),
  .sat_clear  (sat_clear),
  .sat_sticky (sat_sticky)
);

// File: tb/test_hpsum_unit.sv
module test_hpsum_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_a = '0;
  logic [127:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_sum;
  logic         out_sat;
  logic         sat_clear = 1'b0;
  logic         sat_sticky;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  hpsum_unit i_hpsum_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_sat(out_sat), .sat_clear(sat_clear),
    .sat_sticky(sat_sticky)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [127:0] a, input logic [127:0] b,
                                output logic [127:0] r, output logic s);
    s = 1'b0;
    r = '0;
    for (int l = 0; l < 4; l++) begin
      longint acc;
      logic [31:0] wa, wb;
      wa = a[127-32*l -: 32];
      wb = b[127-32*l -: 32];
      acc = longint'($signed(wb)) + longint'($signed(wa[31:16])) +
            longint'($signed(wa[15:0]));
      if (acc > 64'sd2147483647) begin
        acc = 64'sd2147483647; s = 1'b1;
      end else if (acc < -64'sd2147483648) begin
        acc = -64'sd2147483648; s = 1'b1;
      end
      r[127-32*l -: 32] = acc[31:0];
    end
  endfunction

  task automatic push_check(input logic [127:0] a, input logic [127:0] b,
                            input string tag);
    logic [127:0] er;
    logic es;
    model(a, b, er, es);
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {tag, " R8 valid"}, {127'd0, out_valid}, 128'd1);
    check(out_sum === er, {tag, " sum"}, out_sum, er);
    check(out_sat === es, {tag, " R6 sat"}, {127'd0, out_sat}, {127'd0, es});
  endtask

  task automatic t_reset;
    check(out_valid === 1'b0, "R10 out_valid", {127'd0, out_valid}, 128'd0);
    check(sat_sticky === 1'b0, "R10 sticky", {127'd0, sat_sticky}, 128'd0);
    check(in_ready === 1'b1, "R8 ready idle", {127'd0, in_ready}, 128'd1);
  endtask

  task automatic t_basic;
    push_check({32'h0001_0002, 32'hFFFF_FFFF, 32'h7FFF_8000, 32'h1234_4321},
               {32'h0000_0010, 32'h0000_0005, 32'hFFFF_0000, 32'hDEAD_BEEF}, "R1 mix1");
    push_check({32'h8000_7FFF, 32'h0000_0000, 32'hFFFE_FFFD, 32'h0100_0200},
               {32'h1234_5678, 32'h8765_4321, 32'h0000_0003, 32'hFFFF_FD00}, "R1 mix2");
    @(negedge clk);
    check(out_valid === 1'b0, "R8 drained", {127'd0, out_valid}, 128'd0);
  endtask

  task automatic t_limits;
    for (int l = 0; l < 4; l++) begin
      logic [127:0] a, b;
      a = {4{32'h0000_0000}}; b = '0;
      a[127-32*l -: 32] = 32'h7FFF_7FFF;
      b[127-32*l -: 32] = 32'h7FFF_0001;
      push_check(a, b, "R4 exact max");
      check(out_sum[127-32*l -: 32] === 32'h7FFF_FFFF && !out_sat, "R4 max noflag",
            out_sum, b);
      b[127-32*l -: 32] = 32'h7FFF_0002;
      push_check(a, b, "R2 max+1");
      check(out_sum[127-32*l -: 32] === 32'h7FFF_FFFF && out_sat, "R2 clamp hi",
            out_sum, 128'h7FFF_FFFF);
      a[127-32*l -: 32] = 32'h8000_8000;
      b[127-32*l -: 32] = 32'h8001_0000;
      push_check(a, b, "R4 exact min");
      check(out_sum[127-32*l -: 32] === 32'h8000_0000 && !out_sat, "R4 min noflag",
            out_sum, 128'h8000_0000);
      b[127-32*l -: 32] = 32'h8000_FFFF;
      push_check(a, b, "R3 min-1");
      check(out_sum[127-32*l -: 32] === 32'h8000_0000 && out_sat, "R3 clamp lo",
            out_sum, 128'h8000_0000);
    end
  endtask

  task automatic t_independent;
    push_check({32'h7FFF_7FFF, 32'h0003_0004, 32'h8000_8000, 32'hFFFF_0001},
               {32'h7FFF_FFFF, 32'h0000_0100, 32'h8000_0000, 32'h0000_0000}, "R5 mixed");
    check(out_sum[95:64] === 32'h0000_0107 && out_sum[31:0] === 32'h0,
          "R5 neighbours", out_sum, {32'h7FFF_FFFF, 32'h107, 32'h8000_0000, 32'h0});
  endtask

  task automatic t_sticky;
    push_check({4{32'h7FFF_7FFF}}, {4{32'h7FFF_FFFF}}, "R7 set");
    check(sat_sticky === 1'b1, "R7 sticky set", {127'd0, sat_sticky}, 128'd1);
    push_check({4{32'h0001_0001}}, {4{32'h0}}, "R7 plain");
    check(sat_sticky === 1'b1, "R7 sticky held", {127'd0, sat_sticky}, 128'd1);
    @(negedge clk); sat_clear = 1'b1;
    @(negedge clk); sat_clear = 1'b0;
    check(sat_sticky === 1'b0, "R7 cleared", {127'd0, sat_sticky}, 128'd0);
    @(negedge clk);
    in_a = {4{32'h8000_8000}}; in_b = {4{32'h8000_0000}};
    in_valid = 1'b1; sat_clear = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sat_clear = 1'b0;
    check(sat_sticky === 1'b1, "R7 set beats clear", {127'd0, sat_sticky}, 128'd1);
    check(out_sum === {4{32'h8000_0000}} && out_sat, "R3 all lanes", out_sum,
          {4{32'h8000_0000}});
  endtask

  task automatic t_stall;
    logic [127:0] a1, b1, a2, b2, e1, e2;
    logic s1, s2;
    a1 = {4{32'h0002_0003}}; b1 = {4{32'h0000_0010}};
    a2 = {4{32'h7FFF_7FFF}}; b2 = {4{32'h7FFF_0000}};
    model(a1, b1, e1, s1);
    model(a2, b2, e2, s2);
    @(negedge clk);
    out_ready = 1'b0; in_a = a1; in_b = b1; in_valid = 1'b1;
    @(negedge clk);
    in_a = a2; in_b = b2;
    check(out_valid === 1'b1 && out_sum === e1, "R9 held first", out_sum, e1);
    check(in_ready === 1'b0, "R9 ready low", {127'd0, in_ready}, 128'd0);
    @(negedge clk);
    check(out_valid === 1'b1 && out_sum === e1 && out_sat === s1, "R9 still held",
          out_sum, e1);
    out_ready = 1'b1;
    #1;
    check(in_ready === 1'b1, "R8 ready on drain", {127'd0, in_ready}, 128'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_sum === e2 && out_sat === s2, "R8 next result",
          out_sum, e2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_basic;
    t_limits;
    t_independent;
    t_sticky;
    t_stall;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule